// File: doc/BRIEF.md
# Oversampled Serial Character Receiver

This block turns an asynchronous serial input line into parallel characters. It is paced by a baud tick running at a fixed multiple of the bit rate (sixteen by default). On a falling edge of the idle-high line it waits half a bit period to confirm a start bit. It then samples every later bit at the middle of its period and collects 5 to 8 data bits, least significant bit first. The result is presented as a zero-extended byte.

The character format comes from four static inputs: a two-bit length code, a parity enable, an even/odd select and a fixed-parity (stick) select. The format is captured when a start bit is confirmed, so a change during a character affects only the next one. Each character ends with a single-cycle valid strobe. Parity-error, framing-error and break flags are pulsed in the same cycle. After a break the receiver does not hunt for a new start bit until the line has gone high again.

Top module: `uart_rx_core`

## Requirements
- R1: Length code `len_sel_i` values 0, 1, 2, 3 select 5, 6, 7, 8 data bits. The bits are received least significant first and presented on `data_o` with the unused upper bits at 0.
- R2: A low line seen on a baud tick in idle is confirmed as a start bit only if it is still low at the mid-bit sample, 8 ticks later. Otherwise the receiver returns to idle and produces no character.
- R3: With `par_en_i`=1 one parity bit is expected directly after the last data bit and before the stop bit. With `par_en_i`=0 the stop bit follows the last data bit and `par_err_o` is never set.
- R4: With parity enabled and stick parity off, `par_even_i`=1 requires an even number of 1s across the data and parity bits, and `par_even_i`=0 requires an odd number. A mismatch sets `par_err_o`.
- R5: With parity enabled and `par_stick_i`=1, the parity bit must be 1 when `par_even_i`=0 and 0 when `par_even_i`=1. Otherwise `par_err_o` is set.
- R6: Only the first stop bit is sampled, whatever the number of stop bits the sender uses. A 0 there sets `frame_err_o`.
- R7: When all data bits, the parity bit (if enabled) and the first stop bit are 0, `brk_o` is set together with `frame_err_o`. The receiver then ignores the line until it returns high, so a line held low yields exactly one character.
- R8: `rx_valid_o` and the error flags are pulses one clock long, raised at the mid-sample of the first stop bit. No flag is raised without `rx_valid_o`, and `data_o` holds its value between strobes.
- R9: While `rst_ni` is low, `rx_valid_o`, all flags and `data_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| baud_tick_i | input | 1 | One-cycle pulse at OSR times the bit rate |
| rxd_i | input | 1 | Serial input line, idle high |
| len_sel_i | input | 2 | Data length code, 0..3 for 5..8 bits |
| par_en_i | input | 1 | Parity bit present |
| par_even_i | input | 1 | Even parity select |
| par_stick_i | input | 1 | Fixed parity value select |
| data_o | output | 8 | Last received character, zero-extended |
| rx_valid_o | output | 1 | Character strobe |
| par_err_o | output | 1 | Parity mismatch, with strobe |
| frame_err_o | output | 1 | First stop bit was 0, with strobe |
| brk_o | output | 1 | Break detected, with strobe |

## Verification
The assertions check on every cycle that the strobe and flags are single-cycle pulses and that flags appear only with the strobe. They also check that a break always carries a framing error and a zero byte, that bits above the selected length stay 0, and that no parity error appears when parity is off. Only the bench's frames can show the character values, the parity arithmetic under each select combination, the rejection of short start glitches, that the extra stop bits are ignored, and that the receiver waits after a break.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_START, S_DATA, S_PAR, S_STOP, S_BRKW
  } rx_state_e;

  typedef struct packed {
    logic [1:0] len_sel;
    logic       par_en;
    logic       par_even;
    logic       par_stick;
  } rx_cfg_t;
endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q[g] <= 1'b1;
        else if (g == 0) chain_q[g] <= d_i;
        else chain_q[g] <= chain_q[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/uart_rx_bit_timer.sv
module uart_rx_bit_timer #(
  parameter int unsigned OSR = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic run_i,
  input  logic half_i,   // first sample is half a bit after the edge
  output logic sample_o
);
  localparam int unsigned CW  = $clog2(OSR);
  localparam int unsigned MID = OSR / 2;

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] limit;

  assign limit    = half_i ? CW'(MID - 1) : CW'(OSR - 1);
  assign sample_o = run_i && tick_i && (cnt_q == limit);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (!run_i)   cnt_q <= '0;
    else if (sample_o) cnt_q <= '0;
    else if (tick_i)   cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/uart_rx_par_chk.sv
module uart_rx_par_chk #(
  parameter int unsigned DW = 8
) (
  input  logic [DW-1:0] data_i,
  input  logic          par_bit_i,
  input  logic          par_en_i,
  input  logic          par_even_i,
  input  logic          par_stick_i,
  output logic          par_err_o
);
  logic exp_bit;

  always_comb begin
    if (par_stick_i)     exp_bit = ~par_even_i;
    else if (par_even_i) exp_bit = ^data_i;
    else                 exp_bit = ~(^data_i);
  end

  assign par_err_o = par_en_i && (par_bit_i != exp_bit);
endmodule

// File: rtl/uart_rx_core.sv
module uart_rx_core #(
  parameter int unsigned OSR         = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       baud_tick_i,
  input  logic       rxd_i,
  input  logic [1:0] len_sel_i,
  input  logic       par_en_i,
  input  logic       par_even_i,
  input  logic       par_stick_i,
  output logic [7:0] data_o,
  output logic       rx_valid_o,
  output logic       par_err_o,
  output logic       frame_err_o,
  output logic       brk_o
);
  import uart_rx_pkg::*;

  localparam int unsigned DW   = 8;
  localparam int unsigned BW   = $clog2(DW);
  localparam int unsigned MINW = 5;

  rx_state_e      state_q;
  rx_cfg_t        cfg_q;
  logic [DW-1:0]  shreg_q;
  logic [BW-1:0]  idx_q;
  logic [BW-1:0]  last_idx;
  logic           par_q;
  logic           rx_s;
  logic           sample;
  logic           run;
  logic           par_err;
  logic           brk_now;

  uart_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (rxd_i),
    .q_o   (rx_s)
  );

  assign run = (state_q == S_START) || (state_q == S_DATA) ||
               (state_q == S_PAR)   || (state_q == S_STOP);

  uart_rx_bit_timer #(.OSR(OSR)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (baud_tick_i),
    .run_i   (run),
    .half_i  (state_q == S_START),
    .sample_o(sample)
  );

  uart_rx_par_chk #(.DW(DW)) u_par (
    .data_i     (shreg_q),
    .par_bit_i  (par_q),
    .par_en_i   (cfg_q.par_en),
    .par_even_i (cfg_q.par_even),
    .par_stick_i(cfg_q.par_stick),
    .par_err_o  (par_err)
  );

  assign last_idx = BW'(MINW - 1) + BW'(cfg_q.len_sel);
  assign brk_now  = (shreg_q == '0) && !rx_s && !(cfg_q.par_en && par_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= S_IDLE;
      cfg_q       <= '0;
      shreg_q     <= '0;
      idx_q       <= '0;
      par_q       <= 1'b0;
      data_o      <= '0;
      rx_valid_o  <= 1'b0;
      par_err_o   <= 1'b0;
      frame_err_o <= 1'b0;
      brk_o       <= 1'b0;
    end else begin
      rx_valid_o  <= 1'b0;
      par_err_o   <= 1'b0;
      frame_err_o <= 1'b0;
      brk_o       <= 1'b0;
      unique case (state_q)
        S_IDLE: if (baud_tick_i && !rx_s) state_q <= S_START;
        S_START: if (sample) begin
          if (!rx_s) begin
            state_q <= S_DATA;
            cfg_q   <= '{len_sel: len_sel_i, par_en: par_en_i,
                         par_even: par_even_i, par_stick: par_stick_i};
            shreg_q <= '0;
            idx_q   <= '0;
            par_q   <= 1'b0;
          end else begin
            state_q <= S_IDLE;   // glitch, not a start bit
          end
        end
        S_DATA: if (sample) begin
          shreg_q[idx_q] <= rx_s;
          if (idx_q == last_idx) state_q <= cfg_q.par_en ? S_PAR : S_STOP;
          else                   idx_q   <= idx_q + 1'b1;
        end
        S_PAR: if (sample) begin
          par_q   <= rx_s;
          state_q <= S_STOP;
        end
        S_STOP: if (sample) begin
          data_o      <= shreg_q;
          rx_valid_o  <= 1'b1;
          par_err_o   <= par_err;
          frame_err_o <= !rx_s;
          brk_o       <= brk_now;
          state_q     <= brk_now ? S_BRKW : S_IDLE;
        end
        S_BRKW: if (rx_s) state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/uart_rx_core_chk.sv
module uart_rx_core_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [1:0] len_sel_i,
  input logic       par_en_i,
  input logic [7:0] data_o,
  input logic       rx_valid_o,
  input logic       par_err_o,
  input logic       frame_err_o,
  input logic       brk_o
);
  p_valid_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |=> !rx_valid_o);

  p_flags_gated_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (par_err_o || frame_err_o || brk_o) |-> rx_valid_o);

  p_data_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_valid_o |-> $stable(data_o));

  p_brk_frame_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    brk_o |-> (frame_err_o && data_o == 8'h00));

  p_zero_ext_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |-> ((data_o >> (4'd5 + {2'b00, len_sel_i})) == 8'h00));

  p_no_par_off_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid_o && !par_en_i) |-> !par_err_o);

  always_comb begin
    if (!rst_ni) begin
      a_reset_quiet_r9: assert (!rx_valid_o || $isunknown(rx_valid_o));
    end
  end
endmodule

bind uart_rx_core uart_rx_core_chk chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .len_sel_i  (len_sel_i),
  .par_en_i   (par_en_i),
  .data_o     (data_o),
  .rx_valid_o (rx_valid_o),
  .par_err_o  (par_err_o),
  .frame_err_o(frame_err_o),
  .brk_o      (brk_o)
);

// File: tb/uart_rx_core_tb_top.sv
module uart_rx_core_tb_top;
  localparam int TDIV = 4;
  localparam int OSR  = 16;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       baud_tick_i = 1'b0;
  logic       rxd_i = 1'b1;
  logic [1:0] len_sel_i = 2'd3;
  logic       par_en_i = 1'b0;
  logic       par_even_i = 1'b0;
  logic       par_stick_i = 1'b0;
  logic [7:0] data_o;
  logic       rx_valid_o, par_err_o, frame_err_o, brk_o;

  int n_chk = 0;
  int n_bad = 0;
  int n_valid = 0;
  bit done = 0;
  logic [7:0] cap_data;
  logic cap_perr, cap_ferr, cap_brk;

  always #5 clk_i = ~clk_i;

  uart_rx_core dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .baud_tick_i(baud_tick_i), .rxd_i(rxd_i),
    .len_sel_i(len_sel_i), .par_en_i(par_en_i), .par_even_i(par_even_i),
    .par_stick_i(par_stick_i), .data_o(data_o), .rx_valid_o(rx_valid_o),
    .par_err_o(par_err_o), .frame_err_o(frame_err_o), .brk_o(brk_o)
  );

  initial begin : tick_gen
    int ph = 0;
    forever begin
      @(negedge clk_i);
      ph = (ph + 1) % TDIV;
      baud_tick_i = (ph == 0);
    end
  end

  initial begin : monitor
    forever begin
      @(negedge clk_i);
      if (rx_valid_o) begin
        n_valid++;
        cap_data = data_o;
        cap_perr = par_err_o;
        cap_ferr = frame_err_o;
        cap_brk  = brk_o;
      end
    end
  end

  task automatic check(input bit ok, input string req, input int got, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask

  function automatic logic [7:0] mask_of(input logic [1:0] len);
    return 8'hFF >> (3 - len);
  endfunction

  function automatic logic par_of(input logic [7:0] d, input logic even, input logic stick);
    if (stick) return ~even;
    return even ? ^d : ~(^d);
  endfunction

  task automatic hold(input logic b, input int ticks);
    rxd_i = b;
    repeat (ticks * TDIV) @(negedge clk_i);
  endtask

  task automatic frame(input logic [7:0] d, input logic [1:0] len, input logic pen,
                       input logic even, input logic stick, input logic bad_par,
                       input logic stop, input int nstop);
    logic [7:0] dm;
    logic pbit, e_perr, e_brk;
    int v0;
    len_sel_i = len; par_en_i = pen; par_even_i = even; par_stick_i = stick;
    dm = d & mask_of(len);
    pbit = par_of(dm, even, stick) ^ bad_par;
    e_perr = pen && bad_par;
    e_brk = (dm == 0) && !stop && !(pen && pbit);
    v0 = n_valid;
    hold(1'b0, OSR);
    for (int i = 0; i < 5 + int'(len); i++) hold(d[i], OSR);
    if (pen) hold(pbit, OSR);
    if (stop) hold(1'b1, OSR * nstop);
    else if (e_brk) hold(1'b0, OSR * 4);  // line stays low past the frame
    else hold(1'b0, 10);
    hold(1'b1, OSR * 2);
    check(n_valid == v0 + 1, "R8 one strobe", n_valid - v0, 1);
    check(cap_data == dm, pen ? "R3 data" : "R1 data", cap_data, dm);
    check(cap_perr == e_perr, stick ? "R5 parity" : "R4 parity", cap_perr, e_perr);
    check(cap_ferr == !stop, "R6 frame", cap_ferr, !stop);
    check(cap_brk == e_brk, "R7 break", cap_brk, e_brk);
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk_i);
    if (!done) begin
      n_bad++;
      n_chk++;
      $display("FAIL R8 watchdog got=%0h exp=%0h", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : stim
    int v0;
    void'($urandom(32'h5eed_0042));
    repeat (3) @(negedge clk_i);
    check(data_o == 0 && !rx_valid_o && !par_err_o && !frame_err_o && !brk_o,
          "R9 reset", {rx_valid_o, data_o}, 0);
    rst_ni = 1'b1;
    hold(1'b1, OSR);

    // R1: every length, all-ones payload
    for (int l = 0; l < 4; l++) frame(8'hFF, 2'(l), 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1);
    // R4: even and odd, good and bad
    frame(8'hA5, 2'd3, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1);
    frame(8'hA5, 2'd3, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1);
    frame(8'h13, 2'd2, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1);
    // R5: stick parity both senses
    frame(8'h3C, 2'd3, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1);
    frame(8'h3C, 2'd3, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1);
    frame(8'h01, 2'd0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1);
    // R6: two stop bits, then a bad stop
    frame(8'h5A, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 2);
    frame(8'h5A, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1);
    // R7: break without and with parity, then normal traffic
    frame(8'h00, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1);
    frame(8'h00, 2'd1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1);
    frame(8'h00, 2'd3, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1);
    frame(8'h81, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1);
    // R2: short low pulse is not a start bit
    v0 = n_valid;
    hold(1'b0, 3);
    hold(1'b1, OSR * 3);
    check(n_valid == v0, "R2 glitch", n_valid - v0, 0);

    for (int k = 0; k < 100; k++) begin
      logic [7:0] d;
      logic [3:0] r;
      d = 8'($urandom());
      r = 4'($urandom());
      if (r == 0) d = 8'h00;
      frame(d, 2'($urandom()), 1'($urandom()), 1'($urandom()), r[3] & r[2],
            r[1] & r[0], !(r == 0 || r == 4'd5), 1 + (r[0] ? 1 : 0));
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule